// File: doc/BRIEF.md
# Paired-Byte I2C Configuration Register Target

This block is an I2C target that lets a bus master read and write a bank of 16-bit control registers. Each register travels as two 8-bit bytes, high byte first, and every byte goes MSB first. A transfer starts with the 7-bit device address and the direction bit in bit 0, where 1 means read. A write then sends a one-byte register pointer followed by any number of data pairs. A read, usually issued after a repeated START that follows a pointer write, returns pairs starting at the current pointer.

The pointer moves forward by one after each complete pair, in both directions. A register takes a new value only after both bytes of its pair have arrived. The register bank drives configuration outputs to the surrounding logic: a volume word and two equalizer controls. SCL and SDA arrive already synchronized to `clk`. The block drives the bus only through an open-drain pull-down enable.

Top module: `i2c16_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal the DEV_ADDR parameter. For any other address it never pulls SDA low until the next START.
- R2: After its own address with bit 0 at 0 (write), the next byte is acknowledged and loaded as the register pointer.
- R3: Data bytes that follow the pointer form pairs, high byte first. The addressed register takes {high, low} only when the low byte is complete, and the pointer then advances by one, wrapping at 8 bits.
- R4: After its own address with bit 0 at 1 (read), the block sends the register at the pointer as high byte, then low byte. A master ACK after the low byte advances the pointer and sends the next register.
- R5: A master NACK ends the read. SDA is released, and the pointer does not advance past the register just sent.
- R6: A START or STOP that arrives after only the high byte of a pair throws that byte away. No register changes and the pointer does not move.
- R7: Pointer values at or above NUM_REGS are acknowledged on write, but the write has no effect, and a read there returns 0x0000.
- R8: After reset, register 0x11 holds 0x7A40, register 0x12 holds 0x14A2, register 0x14 holds 0x0156, and every other register holds 0x0000.
- R9: `cfg_volume` follows register 0x01. `cfg_eq_bypass` follows bit 1 of register 0x03, and `cfg_eq_five_band` follows bit 0 of register 0x03 (1 = five bands, 0 = ten bands).
- R10: `sda_oe` changes only while SCL is low, except at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |
| cfg_volume | output | 16 | Contents of register 0x01 |
| cfg_eq_bypass | output | 1 | Bit 1 of register 0x03 |
| cfg_eq_five_band | output | 1 | Bit 0 of register 0x03 |

## Verification
The bench builds the block with its default parameters: 48 registers and device address 0x34. With 48 registers the implemented region ends at 0x2F. A random pointer in 0..63 therefore lands on both implemented and unimplemented registers, and bursts that cross 0x2F/0x30 show whether the read-as-zero rule holds as the pointer steps. With a nearby address such as 0x35, the bench checks that the block ignores a transfer meant for another device.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;

    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_RD
    } bus_state_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic              en;
        logic [PTR_W-1:0]  addr;
        logic [WORD_W-1:0] data;
    } reg_wr_t;

    function automatic logic [WORD_W-1:0] reset_value(input int idx);
        case (idx)
            'h11:    return 16'h7A40;
            'h12:    return 16'h14A2;
            'h14:    return 16'h0156;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/i2c16_edge.sv
module i2c16_edge
    import i2c16_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        evt.scl   = scl_i;
        evt.sda   = sda_i;
        evt.rise  = scl_i & ~scl_q;
        evt.fall  = ~scl_i & scl_q;
        evt.start = scl_i & scl_q & sda_q & ~sda_i;
        evt.stop  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c16_regbank.sv
module i2c16_regbank
    import i2c16_pkg::*;
#(
    parameter int NUM_REGS = 48,
    parameter int VOL_IDX  = 1,
    parameter int EQ_IDX   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [WORD_W-1:0] vol_word,
    output logic [1:0]        eq_bits
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [WORD_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= reset_value(i);
            else if (wr.en && wr.addr == PTR_W'(i))
                regs[i] <= wr.data;
        end

        // R6: a register moves only on a commit aimed at it
        p_hold_without_commit_r6: assert property (@(posedge clk) disable iff (rst)
            !(wr.en && wr.addr == PTR_W'(i)) |=> $stable(regs[i]));
    end

    always_comb begin
        if (int'(rd_addr) < NUM_REGS)
            rd_data = regs[rd_addr[IDX_W-1:0]];
        else
            rd_data = '0;
    end

    assign vol_word = regs[VOL_IDX];
    assign eq_bits  = regs[EQ_IDX][1:0];

    // R7: pointers past the bank read as zero
    p_unimpl_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (int'(rd_addr) >= NUM_REGS) |-> (rd_data == '0));
endmodule

// File: rtl/i2c16_engine.sv
module i2c16_engine
    import i2c16_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h34
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [WORD_W-1:0] rd_data,
    output reg_wr_t           wr,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe
);
    bus_state_t        state;
    logic [3:0]        cnt;
    logic [7:0]        shreg;
    logic [7:0]        hi_q;
    logic              in_ack, ack_ok, go_read, lo, tx_on, ack_drv, m_ack;
    logic [7:0]        rx_byte, tx_byte;
    logic              tx_bit;

    assign rx_byte = {shreg[6:0], evt.sda};
    assign tx_byte = lo ? rd_data[7:0] : rd_data[15:8];
    assign tx_bit  = tx_byte[3'd7 - cnt[2:0]];
    assign sda_oe  = ack_drv | (tx_on & ~tx_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            hi_q    <= '0;
            in_ack  <= 1'b0;
            ack_ok  <= 1'b0;
            go_read <= 1'b0;
            lo      <= 1'b0;
            tx_on   <= 1'b0;
            ack_drv <= 1'b0;
            m_ack   <= 1'b0;
            ptr     <= '0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                state   <= ST_ADDR;
                cnt     <= '0;
                in_ack  <= 1'b0;
                ack_drv <= 1'b0;
                tx_on   <= 1'b0;
                lo      <= 1'b0;
            end else if (evt.stop) begin
                state   <= ST_IDLE;
                in_ack  <= 1'b0;
                ack_drv <= 1'b0;
                tx_on   <= 1'b0;
                lo      <= 1'b0;
            end else if (evt.rise) begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (!in_ack) begin
                            shreg <= rx_byte;
                            cnt   <= cnt + 4'd1;
                            if (cnt == 4'd7) begin
                                case (state)
                                    ST_ADDR: begin
                                        ack_ok  <= (rx_byte[7:1] == DEV_ADDR);
                                        go_read <= rx_byte[0];
                                    end
                                    ST_PTR: begin
                                        ptr    <= rx_byte;
                                        ack_ok <= 1'b1;
                                    end
                                    default: begin
                                        ack_ok <= 1'b1;
                                        if (lo) begin
                                            wr.en   <= 1'b1;
                                            wr.addr <= ptr;
                                            wr.data <= {hi_q, rx_byte};
                                        end else begin
                                            hi_q <= rx_byte;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                    ST_RD: if (in_ack) m_ack <= ~evt.sda;
                    default: ;
                endcase
            end else if (evt.fall) begin
                case (state)
                    ST_ADDR, ST_PTR, ST_WR: begin
                        if (!in_ack && cnt == 4'd8) begin
                            in_ack  <= 1'b1;
                            ack_drv <= ack_ok;
                        end else if (in_ack) begin
                            in_ack  <= 1'b0;
                            ack_drv <= 1'b0;
                            cnt     <= '0;
                            case (state)
                                ST_ADDR: begin
                                    if (!ack_ok)
                                        state <= ST_IDLE;
                                    else if (go_read) begin
                                        state <= ST_RD;
                                        tx_on <= 1'b1;
                                        lo    <= 1'b0;
                                    end else
                                        state <= ST_PTR;
                                end
                                ST_PTR: begin
                                    state <= ST_WR;
                                    lo    <= 1'b0;
                                end
                                default: begin
                                    lo <= ~lo;
                                    if (lo) ptr <= ptr + 8'd1;
                                end
                            endcase
                        end
                    end
                    ST_RD: begin
                        if (in_ack) begin
                            in_ack <= 1'b0;
                            if (m_ack) begin
                                cnt   <= '0;
                                tx_on <= 1'b1;
                                lo    <= ~lo;
                                if (lo) ptr <= ptr + 8'd1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else if (cnt == 4'd7) begin
                            cnt    <= '0;
                            tx_on  <= 1'b0;
                            in_ack <= 1'b1;
                        end else begin
                            cnt <= cnt + 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: nothing is driven while the block is not addressed
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R10: the pull-down only moves while SCL is low
    p_oe_steady_scl_high_r10: assert property (@(posedge clk) disable iff (rst)
        (evt.scl && $past(evt.scl) && !$past(evt.start) && !$past(evt.stop))
        |-> $stable(sda_oe));

    // R4: the pointer moves by one step unless a pointer byte is loaded
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 8'd1) || ($past(state) == ST_PTR)));

    // R3: a commit only happens on the low byte of a pair
    p_commit_on_low_r3: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> (lo && state == ST_WR));

    // R5: a master NACK releases the bus on the next cycle
    p_nack_release_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD && in_ack && evt.fall && !m_ack && !evt.start && !evt.stop)
        |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/i2c16_target.sv
module i2c16_target
    import i2c16_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h34,
    parameter int         NUM_REGS = 48,
    parameter int         VOL_IDX  = 1,
    parameter int         EQ_IDX   = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    output logic [15:0] cfg_volume,
    output logic        cfg_eq_bypass,
    output logic        cfg_eq_five_band
);
    bus_evt_t          evt;
    reg_wr_t           wr;
    logic [PTR_W-1:0]  ptr;
    logic [WORD_W-1:0] rd_data;
    logic [1:0]        eq_bits;

    i2c16_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c16_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .wr      (wr),
        .ptr     (ptr),
        .sda_oe  (sda_oe)
    );

    i2c16_regbank #(
        .NUM_REGS (NUM_REGS),
        .VOL_IDX  (VOL_IDX),
        .EQ_IDX   (EQ_IDX)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr       (wr),
        .rd_addr  (ptr),
        .rd_data  (rd_data),
        .vol_word (cfg_volume),
        .eq_bits  (eq_bits)
    );

    assign cfg_eq_bypass    = eq_bits[1];
    assign cfg_eq_five_band = eq_bits[0];
endmodule

// File: tb/i2c16_target_test.sv
module i2c16_target_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;
    localparam logic [6:0] DEV = 7'h34;
    localparam int NREG       = 48;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_bus;
    logic sda_oe;
    logic [15:0] cfg_volume;
    logic cfg_eq_bypass, cfg_eq_five_band;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int r10_viol = 0;
    logic [15:0] model [256];
    logic [7:0]  mptr;

    assign sda_bus = ~(m_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c16_target uut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .cfg_volume(cfg_volume), .cfg_eq_bypass(cfg_eq_bypass),
        .cfg_eq_five_band(cfg_eq_five_band)
    );

    // R10 monitor: SDA pull-down must not move while SCL stays high
    logic prev_scl = 1'b1, prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && scl && prev_scl && (sda_oe != prev_oe)) r10_viol++;
        prev_scl <= scl;
        prev_oe  <= sda_oe;
    end

    function automatic logic [15:0] dflt(input int a);
        if (a == 'h11) return 16'h7A40;
        if (a == 'h12) return 16'h14A2;
        if (a == 'h14) return 16'h0156;
        return 16'h0000;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic phase();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin
            m_low = 1'b0; phase();
            scl = 1'b1; phase();
        end
        m_low = 1'b1; phase();
        scl = 1'b0; phase();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; phase();
        scl = 1'b1; phase();
        m_low = 1'b0; phase();
    endtask

    task automatic send_bit(input bit b);
        m_low = ~b; phase();
        scl = 1'b1; phase();
        scl = 1'b0; phase();
    endtask

    task automatic recv_bit(output bit b);
        m_low = 1'b0; phase();
        scl = 1'b1; phase();
        b = sda_bus;
        scl = 1'b0; phase();
    endtask

    task automatic send_byte(input logic [7:0] d, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    // full write transfer of up to four pairs with model update
    task automatic write_txn(input logic [7:0] p, input int n, input logic [15:0] w0,
                             input logic [15:0] w1, input logic [15:0] w2, input logic [15:0] w3);
        bit ack;
        logic [15:0] w;
        bus_start();
        send_byte({DEV, 1'b0}, ack); chk(ack, "R1 own address ack", 32'(ack), 1);
        send_byte(p, ack);           chk(ack, "R2 pointer ack", 32'(ack), 1);
        mptr = p;
        for (int k = 0; k < n; k++) begin
            w = (k == 0) ? w0 : (k == 1) ? w1 : (k == 2) ? w2 : w3;
            send_byte(w[15:8], ack);
            send_byte(w[7:0], ack);
            chk(ack, "R3/R7 data pair ack", 32'(ack), 1);
            if (int'(mptr) < NREG) model[mptr] = w;
            mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    // pointer write, repeated START, read n pairs, compare with model
    task automatic read_txn(input logic [7:0] p, input int n, input string tag);
        bit ack;
        logic [7:0] hi, lo;
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(p, ack);
        mptr = p;
        bus_start();
        send_byte({DEV, 1'b1}, ack); chk(ack, "R4 read address ack", 32'(ack), 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(hi, 1'b1);
            recv_byte(lo, k != n - 1);
            chk({hi, lo} == model[mptr], tag, {16'h0, hi, lo}, {16'h0, model[mptr]});
            if (k != n - 1) mptr = mptr + 8'd1;
        end
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        logic [7:0] hi, lo;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) model[i] = dflt(i);

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // reset state
        chk(sda_oe == 1'b0, "R1 released after reset", 32'(sda_oe), 0);
        chk(cfg_volume == 16'h0, "R9 volume reset", 32'(cfg_volume), 0);
        chk({cfg_eq_bypass, cfg_eq_five_band} == 2'b00, "R9 eq bits reset",
            32'({cfg_eq_bypass, cfg_eq_five_band}), 0);

        // R8 defaults, burst 0x11..0x14
        read_txn(8'h11, 4, "R8 reset default burst");

        // R1 foreign address is ignored
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, ack);
        chk(!ack, "R1 foreign address nack", 32'(ack), 0);
        send_byte(8'h01, ack); chk(!ack, "R1 foreign pointer nack", 32'(ack), 0);
        send_byte(8'h12, ack);
        send_byte(8'h34, ack); chk(!ack, "R1 foreign data nack", 32'(ack), 0);
        bus_stop();
        read_txn(8'h01, 1, "R1 foreign write had no effect");

        // R9 configuration outputs
        write_txn(8'h01, 1, 16'hABCD, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(cfg_volume == 16'hABCD, "R9 volume word", 32'(cfg_volume), 32'h0000ABCD);
        write_txn(8'h03, 1, 16'h0002, 0, 0, 0);
        chk({cfg_eq_bypass, cfg_eq_five_band} == 2'b10, "R9 bypass set",
            32'({cfg_eq_bypass, cfg_eq_five_band}), 2);
        write_txn(8'h03, 1, 16'hFFF1, 0, 0, 0);
        chk({cfg_eq_bypass, cfg_eq_five_band} == 2'b01, "R9 five band set",
            32'({cfg_eq_bypass, cfg_eq_five_band}), 1);

        // R3 multi-pair write with pointer step
        write_txn(8'h20, 3, 16'h1357, 16'h2468, 16'h9ABC, 0);
        read_txn(8'h20, 3, "R3 pair burst readback");

        // R6 STOP after the high byte
        write_txn(8'h05, 1, 16'h1111, 0, 0, 0);
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h05, ack);
        send_byte(8'hEE, ack);
        bus_stop();
        read_txn(8'h05, 1, "R6 stop mid pair discarded");

        // R6 repeated START after the high byte, read from the unmoved pointer
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h05, ack);
        send_byte(8'h77, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(hi, 1'b1);
        recv_byte(lo, 1'b0);
        bus_stop();
        chk({hi, lo} == 16'h1111, "R6 restart mid pair discarded", {16'h0, hi, lo}, 32'h1111);

        // R7 unimplemented pointer
        write_txn(8'h80, 1, 16'hBEEF, 0, 0, 0);
        read_txn(8'h80, 1, "R7 unimplemented reads zero");
        write_txn(8'h2F, 1, 16'h5A5A, 0, 0, 0);
        read_txn(8'h2F, 3, "R7 burst across bank end");

        // R5 NACK ends the read and the pointer stays
        bus_start();
        send_byte({DEV, 1'b0}, ack);
        send_byte(8'h11, ack);
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(hi, 1'b1);
        recv_byte(lo, 1'b0);
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R5 bus released after nack", 32'(sda_oe), 0);
        bus_stop();
        bus_start();
        send_byte({DEV, 1'b1}, ack);
        recv_byte(hi, 1'b1);
        recv_byte(lo, 1'b0);
        bus_stop();
        chk({hi, lo} == 16'h7A40, "R5 pointer held after nack", {16'h0, hi, lo}, 32'h7A40);

        // R4 random bursts
        for (int it = 0; it < 30; it++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom_range(63));
            n = int'($urandom_range(3, 1));
            write_txn(p, n, 16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
            read_txn(p, n + 1, "R4 random burst readback");
        end

        chk(r10_viol == 0, "R10 sda_oe steady while SCL high", 32'(r10_viol), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule